// File: doc/BRIEF.md
# Page Buffer with Timed Write Commit

This block sits between the serial protocol engine of a small non-volatile memory and its storage array. It collects the data bytes of one write transfer in a page buffer of `PAGE_BYTES` entries. It commits them to the array in a single internally timed write cycle, which begins when the transfer ends with a stop. The protocol engine gives it four things: a starting word address, a strobe for each received data byte, a strobe for each start and stop condition, and the level of the write-protect pin.

The low `log2(PAGE_BYTES)` bits of the shared word-address counter step after every captured byte. They wrap inside the page, and the upper bits never move, so a long transfer folds back onto the same page. When a stop arrives with data buffered and protection off, the block raises `busy` for exactly `WR_CYCLES` clocks. In that time it drives the array write port once for each buffer slot that received data, and it ignores every input. If protection is on, a stop discards the buffer and no write cycle starts. A start condition that arrives before the stop also discards the buffer.

`WR_CYCLES` must be at least `PAGE_BYTES`. `PAGE_BYTES` must be a power of two. The word-address counter is a port, so read logic can share it.

Top module: `pageWriteCommit`

## Requirements
- R1: After reset `busy` is 0, `memWe` is 0 and `wordAddr` is 0.
- R2: While not busy, an `addrLoad` strobe sets `wordAddr` to `addrIn` on the next clock.
- R3: Each `byteValid` strobe accepted while not busy stores `byteIn` in buffer slot `wordAddr[3:0]` (default 16-byte page). It then increments only those low 4 bits modulo 16, and `wordAddr[8:4]` stays unchanged.
- R4: A `stopEvt` while not busy, with at least one buffered byte and `wpPin` low, sets `busy` on the next clock and holds it for exactly `WR_CYCLES` clocks.
- R5: During a commit, `memWe` pulses exactly once for each buffer slot that received data, and never for the other slots. `memAddr` holds the buffered page in bits [8:4] and the slot in bits [3:0]. `memWData` carries the last byte captured for that slot, so a single byte is committed like a one-byte page.
- R6: A `stopEvt` with `wpPin` high produces no `memWe` and no `busy`, and it empties the buffer.
- R7: A `startEvt` accepted before the stop empties the buffer, so the following stop writes nothing and does not raise `busy`.
- R8: While `busy` is high, `addrLoad`, `byteValid`, `startEvt` and `stopEvt` have no effect: `wordAddr` does not change, and no byte is captured for a later commit.
- R9: After a commit, `wordAddr` equals the last captured address plus one, wrapped within the page.
- R10: A `stopEvt` with an empty buffer does not raise `busy` and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrLoad | input | 1 | Load the word-address counter from `addrIn` |
| addrIn | input | ADDR_W | Starting word address |
| byteValid | input | 1 | One received data byte on `byteIn` |
| byteIn | input | DATA_W | Received data byte |
| startEvt | input | 1 | Start condition seen on the bus |
| stopEvt | input | 1 | Stop condition seen on the bus |
| wpPin | input | 1 | Write-protect level; high blocks every array write |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memWData | output | DATA_W | Array write data |
| wordAddr | output | ADDR_W | Shared word-address counter |
| busy | output | 1 | Timed write cycle in progress |

## Verification
Random transfers vary the starting offset, the length (1 to 40 bytes) and the protect level. Short transfers show that untouched slots keep their old contents. Transfers that run past the page end show whether the offset wraps onto the same page rather than carrying into the upper bits. Transfers longer than a page show whether only the final value per slot is committed. Directed cases cover one-byte writes, protected stops, empty stops, a start that discards data, and a burst of strobes during the busy window; the last one tells a real lockout apart from one that only blocks the array port.

// File: rtl/pwcPkg.sv
package pwcPkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadAddr;  // take addrIn into the word counter
    logic capture;   // store byteIn at the current offset
    logic discard;   // empty the valid mask
    logic scanWr;    // commit scan is in its write window
  } pwcStrobe_t;
endpackage

// File: rtl/pwcCtrl.sv
module pwcCtrl
  import pwcPkg::*;
#(
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1250
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          addrLoad,
  input  logic                          byteValid,
  input  logic                          startEvt,
  input  logic                          stopEvt,
  input  logic                          wpPin,
  input  logic                          anyValid,
  output pwcStrobe_t                    strobe,
  output logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic                          busy
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             busyQ;
  logic             commitGo;
  logic             lastCyc;

  assign commitGo = !busyQ && stopEvt && !wpPin && anyValid;
  assign lastCyc  = busyQ && (cnt == CNT_W'(WR_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cnt   <= '0;
    end else if (commitGo) begin
      busyQ <= 1'b1;
      cnt   <= '0;
    end else if (lastCyc) begin
      busyQ <= 1'b0;
      cnt   <= '0;
    end else if (busyQ) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobe.loadAddr = !busyQ && addrLoad;
    strobe.capture  = !busyQ && byteValid;
    strobe.discard  = (!busyQ && (startEvt || (stopEvt && wpPin))) || lastCyc;
    strobe.scanWr   = busyQ && (cnt < CNT_W'(PAGE_BYTES));
  end

  assign scanIdx = cnt[IDX_W-1:0];
  assign busy    = busyQ;
endmodule

// File: rtl/pwcDatapath.sv
module pwcDatapath
  import pwcPkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwcStrobe_t                    strobe,
  input  logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  input  logic [ADDR_W-1:0]             addrIn,
  input  logic [DATA_W-1:0]             byteIn,
  output logic                          anyValid,
  output logic                          memWe,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [DATA_W-1:0]             memWData,
  output logic [ADDR_W-1:0]             wordAddr
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0]     addrQ;
  logic [PAGE_BYTES-1:0] vldVec;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];

  // Word counter: the offset steps and wraps, the page bits hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.loadAddr) begin
      addrQ <= addrIn;
    end else if (strobe.capture) begin
      addrQ[IDX_W-1:0] <= addrQ[IDX_W-1:0] + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    logic              hit;
    logic              vldQ;
    logic [DATA_W-1:0] dataQ;

    assign hit = strobe.capture && (addrQ[IDX_W-1:0] == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit) dataQ <= byteIn;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               vldQ <= 1'b0;
      else if (strobe.discard) vldQ <= 1'b0;
      else if (hit)            vldQ <= 1'b1;
    end

    assign vldVec[g]   = vldQ;
    assign slotData[g] = dataQ;
  end

  assign anyValid = |vldVec;
  assign memWe    = strobe.scanWr && vldVec[scanIdx];
  assign memAddr  = {addrQ[ADDR_W-1:IDX_W], scanIdx};
  assign memWData = slotData[scanIdx];
  assign wordAddr = addrQ;
endmodule

// File: rtl/pageWriteCommit.sv
module pageWriteCommit
  import pwcPkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic              wpPin,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              busy
);
  localparam int IDX_W = $clog2(PAGE_BYTES);

  pwcStrobe_t       strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             anyValid;

  pwcCtrl #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteValid(byteValid),
    .startEvt(startEvt), .stopEvt(stopEvt), .wpPin(wpPin),
    .anyValid(anyValid), .strobe(strobe), .scanIdx(scanIdx), .busy(busy)
  );

  pwcDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIdx(scanIdx),
    .addrIn(addrIn), .byteIn(byteIn), .anyValid(anyValid),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData), .wordAddr(wordAddr)
  );
endmodule

// File: rtl/pwcChecker.sv
module pwcChecker #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 1250
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic              byteValid,
  input logic              stopEvt,
  input logic              wpPin,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              busy
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R4: busy window is exactly WR_CYCLES long
  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyLen < CNT_W'(WR_CYCLES - 1)) |=> busy);
  a_r4_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busy && busyLen == CNT_W'(WR_CYCLES - 1)) |=> !busy);
  // R5: array writes only inside a commit and only to the held page
  a_r5_we_in_commit: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
  a_r5_same_page: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1:IDX_W] == wordAddr[ADDR_W-1:IDX_W]));
  // R6: protected stop never starts a write cycle
  a_r6_wp_veto: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopEvt && wpPin) |=> !busy);
  // R8: address counter is frozen during the lockout
  a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(wordAddr));
  // R3: byte capture leaves the page bits alone
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteValid && !addrLoad) |=>
      (wordAddr[ADDR_W-1:IDX_W] == $past(wordAddr[ADDR_W-1:IDX_W])));
endmodule

bind pageWriteCommit pwcChecker #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteValid(byteValid),
  .stopEvt(stopEvt), .wpPin(wpPin), .memWe(memWe), .memAddr(memAddr),
  .wordAddr(wordAddr), .busy(busy)
);

// File: tb/tb_pageWriteCommit.sv
module tb_pageWriteCommit;
  localparam int WR = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrLoad = 1'b0, byteValid = 1'b0, startEvt = 1'b0, stopEvt = 1'b0, wpPin = 1'b0;
  logic [8:0] addrIn = '0;
  logic [7:0] byteIn = '0;
  logic       memWe, busy;
  logic [8:0] memAddr, wordAddr;
  logic [7:0] memWData;

  int checks = 0, fails = 0;
  bit done = 0;
  int wrCount = 0;
  logic [7:0] seenMem [512];
  logic [7:0] expMem  [512];

  always #2 clk = ~clk;

  pageWriteCommit #(.WR_CYCLES(WR)) dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteValid(byteValid), .byteIn(byteIn), .startEvt(startEvt),
    .stopEvt(stopEvt), .wpPin(wpPin), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .wordAddr(wordAddr), .busy(busy)
  );

  // Array model fed only from the write port
  always @(negedge clk) begin
    if (rstN && memWe) begin
      seenMem[memAddr] = memWData;
      wrCount++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic ld, input logic [8:0] a, input logic bv,
                       input logic [7:0] b, input logic st, input logic sp);
    @(negedge clk);
    addrLoad = ld; addrIn = a; byteValid = bv; byteIn = b;
    startEvt = st; stopEvt = sp;
    @(posedge clk);
    #1;
    addrLoad = 0; byteValid = 0; startEvt = 0; stopEvt = 0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // mode 0: plain, 1: strobes during busy, 2: start before stop
  task automatic runTxn(input logic [8:0] a, input int n, input logic wp, input int mode);
    logic [7:0] refBuf [16];
    bit         refVld [16];
    logic [3:0] off = a[3:0];
    logic [8:0] expAddr;
    int         expWr = 0, busyCnt = 0, diffs = 0;
    bit         commit;
    for (int k = 0; k < 16; k++) refVld[k] = 0;
    pulse(0, 0, 0, 0, 1, 0);
    pulse(1, a, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      refBuf[off] = b;
      refVld[off] = 1;
      off++;
      pulse(0, 0, 1, b, 0, 0);
    end
    expAddr = {a[8:4], off};
    check(wordAddr == expAddr, "R3", "offset after capture", wordAddr, expAddr);
    if (mode == 2) begin
      pulse(0, 0, 0, 0, 1, 0);
      for (int k = 0; k < 16; k++) refVld[k] = 0;
    end
    commit = !wp && (n > 0) && (mode != 2);
    if (commit)
      for (int k = 0; k < 16; k++)
        if (refVld[k]) begin
          expMem[{a[8:4], 4'(k)}] = refBuf[k];
          expWr++;
        end
    wrCount = 0;
    wpPin = wp;
    pulse(0, 0, 0, 0, 0, 1);
    @(negedge clk);
    if (!commit)
      check(busy == 0, wp ? "R6" : (mode == 2 ? "R7" : "R10"), "busy on no-commit stop", busy, 0);
    else begin
      check(busy == 1, "R4", "busy after stop", busy, 1);
      busyCnt = 1;
      if (mode == 1) begin
        pulse(1, ~a, 0, 0, 0, 0);
        pulse(0, 0, 1, 8'hA5, 0, 0);
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 1, 8'h5A, 0, 0);
        pulse(0, 0, 0, 0, 0, 1);
        busyCnt += 5;
      end
      while (busy && busyCnt < 10000) begin
        @(negedge clk);
        if (busy) busyCnt++;
      end
      check(busyCnt == WR, "R4", "busy length", busyCnt, WR);
    end
    repeat (2) @(negedge clk);
    check(wrCount == expWr, commit ? "R5" : "R6", "array write count", wrCount, expWr);
    for (int k = 0; k < 512; k++) if (seenMem[k] !== expMem[k]) diffs++;
    check(diffs == 0, "R5", "array contents mismatches", diffs, 0);
    check(wordAddr == expAddr, commit ? "R9" : "R3", "address after stop", wordAddr, expAddr);
    if (mode == 1) begin
      // Bytes sent while busy must not have been kept for a later commit
      wpPin = 0;
      wrCount = 0;
      pulse(0, 0, 0, 0, 0, 1);
      @(negedge clk);
      check(busy == 0, "R8", "stop after busy-time bytes", busy, 0);
      repeat (2) @(negedge clk);
      check(wrCount == 0, "R8", "writes from busy-time bytes", wrCount, 0);
    end
    waitIdle();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    for (int k = 0; k < 512; k++) begin seenMem[k] = 0; expMem[k] = 0; end
    repeat (3) @(negedge clk);
    check(busy == 0 && memWe == 0, "R1", "busy/we after reset", {busy, memWe}, 0);
    check(wordAddr == 0, "R1", "address after reset", wordAddr, 0);
    rstN = 1;
    @(negedge clk);
    pulse(1, 9'h1A7, 0, 0, 0, 0);
    @(negedge clk);
    check(wordAddr == 9'h1A7, "R2", "address load", wordAddr, 9'h1A7);
    // Directed corners
    runTxn(9'h035, 1, 0, 0);   // R5 one-byte write
    runTxn(9'h040, 16, 0, 0);  // full page
    runTxn(9'h10E, 5, 0, 0);   // R3 wrap inside page
    runTxn(9'h0F3, 21, 0, 0);  // R5 overwrite after wrap
    runTxn(9'h0F3, 6, 1, 0);   // R6 protected
    runTxn(9'h122, 4, 0, 2);   // R7 start discards
    runTxn(9'h0C8, 0, 0, 0);   // R10 empty stop
    runTxn(9'h18B, 3, 0, 1);   // R8 strobes during busy
    for (int t = 0; t < 40; t++)
      runTxn(9'($urandom), 1 + int'($urandom % 40), ($urandom % 4) == 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule